// File: doc/BRIEF.md
# Wide Control Word Expander

This unit sits between a 16-bit instruction fetch stage and the datapath control of a signal-processing core. Each fetched opcode is inspected: if its upper byte equals a fixed prefix, the opcode is an expansion opcode, and its low byte selects one of 256 entries in a writable table of 96-bit control words. That entry is issued as a single wide parallel operation. The control word drives the multipliers, the 16-bit ALUs and registers, the shifters, the saturation logic, the address units and the data moves. Every other opcode is handed on unchanged to the ordinary decoder.

The table can be reloaded through a write port while the core runs, so the set of wide operations can be tuned to the algorithm being executed. Both outputs are registered with one cycle of latency, so an expanded word and a passed-through opcode leave the unit in the same cycle relative to their fetch. A write and a read of the same entry in the same cycle return the old contents. The new contents are returned from the next cycle on.

Top module: `wide_ctrl_expander`

## Requirements
- R1: While reset is asserted and right after it, `ctrl_valid_o` and `pass_valid_o` are low and `ctrl_o` and `pass_o` are all zeros.
- R2: A valid opcode whose bits [15:8] equal the prefix 8'hE5 raises `ctrl_valid_o` one cycle later. In that cycle `ctrl_o` carries the table entry indexed by the opcode's bits [7:0], and `pass_valid_o` stays low.
- R3: A valid opcode whose bits [15:8] differ from 8'hE5 raises `pass_valid_o` one cycle later with `pass_o` equal to that opcode, and `ctrl_valid_o` stays low.
- R4: `ctrl_valid_o` and `pass_valid_o` are never high together. `ctrl_o` is zero whenever `ctrl_valid_o` is low, and `pass_o` is zero whenever `pass_valid_o` is low.
- R5: A cycle with `insn_valid_i` low leaves both valid outputs low in the next cycle, whatever the opcode bits are.
- R6: A table write to index k is returned by every expansion of k fetched in the cycle after the write or later.
- R7: An expansion of index k fetched in the same cycle as a write to index k returns the contents k held before that write.
- R8: A write to one index leaves every other entry unchanged.
- R9: All 256 indices can be addressed, including 0 and 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_i | input | 16 | Fetched opcode |
| insn_valid_i | input | 1 | `insn_i` holds an opcode this cycle |
| tbl_we_i | input | 1 | Table write enable |
| tbl_idx_i | input | 8 | Table entry to write |
| tbl_data_i | input | 96 | Control word to write |
| ctrl_o | output | 96 | Expanded control word, zero when not valid |
| ctrl_valid_o | output | 1 | `ctrl_o` carries an expanded operation |
| pass_o | output | 16 | Opcode passed to the normal decoder, zero when not valid |
| pass_valid_o | output | 1 | `pass_o` carries an ordinary opcode |

## Verification
A wrong table entry does not show at the ports until an expansion opcode selects that index. The bench therefore writes every entry and then reads each one back, including the two end indices, so that corrupted storage or a wrong address decode appears as a mismatch on `ctrl_o` one cycle after the fetch. A wrong prefix decode or a wrong pipeline register shows up one cycle after the opcode: the wrong valid flag rises, or the output word is wrong. A collision read that returns the new contents is caught by issuing a write and an expansion of the same index in one cycle.

// File: rtl/wide_ctrl_expander.sv
module wide_ctrl_expander #(
  parameter int OP_W  = 16,
  parameter int CW_W  = 96,
  parameter int IDX_W = 8,
  parameter logic [OP_W-IDX_W-1:0] PREFIX = 8'hE5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  insn_i,
  input  logic             insn_valid_i,
  input  logic             tbl_we_i,
  input  logic [IDX_W-1:0] tbl_idx_i,
  input  logic [CW_W-1:0]  tbl_data_i,
  output logic [CW_W-1:0]  ctrl_o,
  output logic             ctrl_valid_o,
  output logic [OP_W-1:0]  pass_o,
  output logic             pass_valid_o
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int PFX_W = OP_W - IDX_W;

  logic [CW_W-1:0] tbl [DEPTH];
  logic [CW_W-1:0] rd_q;
  logic [OP_W-1:0] op_q;
  logic            exp_q, pass_q;

  wire is_exp = insn_i[OP_W-1 -: PFX_W] == PREFIX;
  wire hit    = insn_valid_i && is_exp;

  always_ff @(posedge clk) begin
    if (tbl_we_i) tbl[tbl_idx_i] <= tbl_data_i;
    if (hit) rd_q <= tbl[insn_i[IDX_W-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q  <= 1'b0;
      pass_q <= 1'b0;
      op_q   <= '0;
    end else begin
      exp_q  <= hit;
      pass_q <= insn_valid_i && !is_exp;
      if (insn_valid_i && !is_exp) op_q <= insn_i;
    end
  end

  assign ctrl_valid_o = exp_q;
  assign pass_valid_o = pass_q;
  assign ctrl_o = exp_q ? rd_q : '0;
  assign pass_o = pass_q ? op_q : '0;

  p_one_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_valid_o && pass_valid_o));
  p_ctrl_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_valid_o |-> ctrl_o == '0);
  p_expand_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid_i && insn_i[OP_W-1 -: PFX_W] == PREFIX |=> ctrl_valid_o);
  p_pass_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid_i && insn_i[OP_W-1 -: PFX_W] != PREFIX |=> pass_valid_o && pass_o == $past(insn_i));
  p_no_fetch_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid_i |=> !ctrl_valid_o && !pass_valid_o);
endmodule

// File: tb/tb_wide_ctrl_expander.sv
module tb_wide_ctrl_expander;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] PFX = 8'hE5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] insn_i = '0;
  logic        insn_valid_i = 1'b0;
  logic        tbl_we_i = 1'b0;
  logic [7:0]  tbl_idx_i = '0;
  logic [95:0] tbl_data_i = '0;
  logic [95:0] ctrl_o;
  logic        ctrl_valid_o;
  logic [15:0] pass_o;
  logic        pass_valid_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [95:0] model [256];

  wide_ctrl_expander dut (
    .clk(clk), .rst_n(rst_n), .insn_i(insn_i), .insn_valid_i(insn_valid_i),
    .tbl_we_i(tbl_we_i), .tbl_idx_i(tbl_idx_i), .tbl_data_i(tbl_data_i),
    .ctrl_o(ctrl_o), .ctrl_valid_o(ctrl_valid_o), .pass_o(pass_o),
    .pass_valid_o(pass_valid_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [95:0] got, input logic [95:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [95:0] rnd96();
    return {$urandom, $urandom, $urandom};
  endfunction

  function automatic logic exp_hit(input logic v, input logic [15:0] ins);
    return v && ins[15:8] == PFX;
  endfunction

  task automatic step(input logic v, input logic [15:0] ins, input logic we,
                      input logic [7:0] wi, input logic [95:0] wd, input string tag);
    logic        e_cv, e_pv;
    logic [95:0] e_c;
    logic [15:0] e_p;
    e_cv = exp_hit(v, ins);
    e_pv = v && !e_cv;
    e_c  = e_cv ? model[ins[7:0]] : '0;
    e_p  = e_pv ? ins : '0;
    insn_valid_i = v; insn_i = ins; tbl_we_i = we; tbl_idx_i = wi; tbl_data_i = wd;
    @(posedge clk);
    if (we) model[wi] = wd;
    #1;
    chk(tag, "ctrl_valid_o", {95'd0, ctrl_valid_o}, {95'd0, e_cv});
    chk(tag, "pass_valid_o", {95'd0, pass_valid_o}, {95'd0, e_pv});
    chk(tag, "ctrl_o", ctrl_o, e_c);
    chk(tag, "pass_o", {80'd0, pass_o}, {80'd0, e_p});
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [95:0] d;
    void'($urandom(32'd2024));
    insn_valid_i = 1'b1; insn_i = {PFX, 8'h10};
    repeat (3) @(negedge clk);
    chk("R1", "ctrl_valid_o in reset", {95'd0, ctrl_valid_o}, 96'd0);
    chk("R1", "pass_valid_o in reset", {95'd0, pass_valid_o}, 96'd0);
    chk("R1", "ctrl_o in reset", ctrl_o, 96'd0);
    chk("R1", "pass_o in reset", {80'd0, pass_o}, 96'd0);
    insn_valid_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ctrl_valid_o after reset", {95'd0, ctrl_valid_o}, 96'd0);
    chk("R1", "pass_valid_o after reset", {95'd0, pass_valid_o}, 96'd0);

    // fill the table with fetch idle; prefix bits on insn must be ignored (R5)
    for (int i = 0; i < 256; i++) step(1'b0, {PFX, 8'(i)}, 1'b1, 8'(i), rnd96(), "R5");

    // read back every entry, ends included (R9, R6)
    step(1'b1, {PFX, 8'h00}, 1'b0, 8'h00, '0, "R9");
    step(1'b1, {PFX, 8'hFF}, 1'b0, 8'h00, '0, "R9");
    for (int i = 0; i < 256; i++) step(1'b1, {PFX, 8'(i)}, 1'b0, 8'h00, '0, "R6");

    // ordinary opcodes, one bit away from the prefix (R3)
    step(1'b1, 16'hE4_05, 1'b0, 8'h00, '0, "R3");
    step(1'b1, 16'hF5_05, 1'b0, 8'h00, '0, "R3");
    step(1'b1, 16'h0000, 1'b0, 8'h00, '0, "R3");

    // collision: same-cycle write returns old, next cycle returns new (R7, R6)
    d = rnd96();
    step(1'b1, {PFX, 8'h05}, 1'b1, 8'h05, d, "R7");
    step(1'b1, {PFX, 8'h05}, 1'b0, 8'h00, '0, "R6");
    chk("R6", "new entry 5", ctrl_o, d);

    // neighbour untouched (R8)
    step(1'b0, 16'h0, 1'b1, 8'h06, rnd96(), "R8");
    step(1'b1, {PFX, 8'h07}, 1'b0, 8'h00, '0, "R8");
    step(1'b1, {PFX, 8'h05}, 1'b0, 8'h00, '0, "R8");

    // mixed random traffic, runtime reloads included (R2, R3, R4, R5)
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] ins;
      ins = ($urandom % 10 < 4) ? {PFX, 8'($urandom)} : 16'($urandom);
      step(($urandom % 4) != 0, ins, ($urandom % 3) == 0, 8'($urandom), rnd96(),
           ins[15:8] == PFX ? "R2" : "R4");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule